// File: doc/BRIEF.md
# Two-Stage Card Clock Enable Divider

This block derives two slower clock rates from a single fast source clock without creating new clock domains. The first stage divides the source by a power of two (1, 2, 4, 8 or 16) to form an intermediate high-speed rate. The second stage divides that intermediate rate by 2 or 4 to form the card rate, so the card rate is the source divided by 2, 4, 8, 16, 32 or 64. Both rates are delivered as single-cycle enable pulses on the source clock. Downstream logic uses these pulses as clock enables, so everything stays synchronous.

Software controls the block through one 32-bit control word, written with a write strobe and read back on a read-data port. The word holds one stop bit per stage and one ratio code per stage. Some code values are not legal. When the programmed codes are illegal, an error flag is raised and both pulse outputs are muted. The divider keeps counting with its last legal ratio until a legal combination is written.

A new ratio does not cut short a period that is already under way. The new ratio takes effect at the next period boundary of the slowest running stage, or at once if both stages are stopped. Releasing a stop bit starts the stage from zero, so its first pulse arrives exactly one full period after the write.

Top module: `sdclk_div`

## Requirements
- R1: Synchronous active-high reset sets the control word to 0x0000_0300: both stop bits set and both codes zero. While reset is held and in the cycle after it, hiEn and cardEn are 0 and cfgErr is 0.
- R2: A write stores wrData in the control word, with effect in the cycle after the write. rdData returns the stored word. Only bits 9, 8 and 4:0 are kept, and every other bit reads as 0.
- R3: Bits 4:2 hold the first-stage code. Codes 0 to 4 give an intermediate period of 1, 2, 4, 8 or 16 source cycles. hiEn pulses high for one cycle once per period while bit 9 is 0 and the codes are legal.
- R4: Bits 1:0 hold the second-stage code. Code 0 gives a card period of 2 intermediate periods and code 1 gives 4. Every cardEn pulse coincides with an hiEn pulse.
- R5: Bit 9 = 1 stops the intermediate stage and holds both hiEn and cardEn at 0. Bit 8 = 1 stops the card stage and holds cardEn at 0. The card stage runs only when both bits are 0.
- R6: First-stage codes 5 to 7 and second-stage codes 2 and 3 are illegal. While the stored word holds an illegal code, cfgErr is 1 and both hiEn and cardEn are 0. The last legal ratio stays in force.
- R7: A legal ratio change is applied at a period boundary, and the emitted pulses never show a shortened or stretched period:
  - With the card stage running, it is applied at the end of the current card period.
  - With only the intermediate stage running, it is applied at the end of the current intermediate period.
  - With both stages stopped, it is applied with the write.
- R8: When a stop bit is cleared, that stage restarts from zero. Counting the write cycle as cycle 0, the first hiEn pulse appears in cycle D1 and the first cardEn pulse in cycle D1×D2, where D1 and D2 are the stage ratios. A pulse never appears in the write cycle.
- R9: cardEn is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast source clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Control word write strobe |
| wrData | input | 32 | Control word write data |
| rdData | output | 32 | Stored control word |
| hiEn | output | 1 | Intermediate-rate enable pulse |
| cardEn | output | 1 | Card-rate enable pulse |
| cfgErr | output | 1 | Illegal ratio codes programmed |

## Verification
A write takes effect one cycle after the write cycle. At that point rdData and cfgErr show the new word and the mute rules apply. A released stage produces its first pulse D1 or D1×D2 cycles after the write, and a ratio change is seen only after the pulse that closes the current period. The bench keeps a cycle-level behavioural model that is updated on each rising edge from the same inputs as the design. It compares all four outputs on every falling edge, so each result is checked in exactly the cycle it is due. Directed latency measurements also count the falling edges from the write cycle to the first pulse of each stage.

// File: rtl/sdclk_div_pkg.sv
package sdclk_div_pkg;

  // Field layout of the control word (software visible, fixed).
  localparam int STOP_HI_BIT   = 9;
  localparam int STOP_CARD_BIT = 8;
  localparam int PRE_LSB       = 2;
  localparam int PRE_W         = 3;
  localparam int POST_LSB      = 0;
  localparam int POST_W        = 2;

  // Strobes from control to datapath.
  typedef struct packed {
    logic              runHi;
    logic              runCard;
    logic              load;
    logic [PRE_W-1:0]  newPre;
    logic [POST_W-1:0] newPost;
    logic              mute;
  } dpCmd_t;

  // Status from datapath back to control.
  typedef struct packed {
    logic              hiTick;
    logic              cardTick;
    logic [PRE_W-1:0]  actPre;
    logic [POST_W-1:0] actPost;
  } dpStat_t;

endpackage

// File: rtl/sdclk_div_ctrl.sv
module sdclk_div_ctrl
  import sdclk_div_pkg::*;
#(
  parameter int DATA_W        = 32,
  parameter int MAX_PRE_CODE  = 4,
  parameter int MAX_POST_CODE = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  dpStat_t           stat,
  output dpCmd_t            cmd,
  output logic [DATA_W-1:0] rdData,
  output logic              cfgErr
);

  localparam logic [DATA_W-1:0] KEEP_MASK =
      (DATA_W'(1) << STOP_HI_BIT) | (DATA_W'(1) << STOP_CARD_BIT) |
      (DATA_W'((1 << PRE_W) - 1) << PRE_LSB) |
      (DATA_W'((1 << POST_W) - 1) << POST_LSB);
  localparam logic [DATA_W-1:0] RESET_WORD =
      (DATA_W'(1) << STOP_HI_BIT) | (DATA_W'(1) << STOP_CARD_BIT);

  logic [DATA_W-1:0] ctrlQ;
  logic [DATA_W-1:0] nextWord;
  logic [PRE_W-1:0]  curPre, nextPre;
  logic [POST_W-1:0] curPost, nextPost;
  logic              runHi, runCard;
  logic              nextLegal, differs, boundary;

  // Control word register
  always_ff @(posedge clk) begin
    if (rst)       ctrlQ <= RESET_WORD;
    else if (wrEn) ctrlQ <= wrData & KEEP_MASK;
  end

  assign nextWord = wrEn ? (wrData & KEEP_MASK) : ctrlQ;
  assign curPre   = ctrlQ[PRE_LSB +: PRE_W];
  assign curPost  = ctrlQ[POST_LSB +: POST_W];
  assign nextPre  = nextWord[PRE_LSB +: PRE_W];
  assign nextPost = nextWord[POST_LSB +: POST_W];

  // Stage run state follows the stored stop bits.
  assign runHi   = ~ctrlQ[STOP_HI_BIT];
  assign runCard = runHi & ~ctrlQ[STOP_CARD_BIT];

  // Legality of the stored and the incoming ratio codes
  assign cfgErr    = (int'(curPre) > MAX_PRE_CODE) || (int'(curPost) > MAX_POST_CODE);
  assign nextLegal = (int'(nextPre) <= MAX_PRE_CODE) && (int'(nextPost) <= MAX_POST_CODE);

  // A change waits for the boundary of the slowest running stage.
  assign differs  = (nextPre != stat.actPre) || (nextPost != stat.actPost);
  always_comb begin
    if (runCard)    boundary = stat.cardTick;
    else if (runHi) boundary = stat.hiTick;
    else            boundary = 1'b1;
  end

  always_comb begin
    cmd.runHi   = runHi;
    cmd.runCard = runCard;
    cmd.load    = nextLegal & differs & boundary;
    cmd.newPre  = nextPre;
    cmd.newPost = nextPost;
    cmd.mute    = cfgErr;
  end

  assign rdData = ctrlQ;

endmodule

// File: rtl/sdclk_div_datapath.sv
module sdclk_div_datapath
  import sdclk_div_pkg::*;
#(
  parameter int MAX_PRE_CODE  = 4,
  parameter int MAX_POST_CODE = 1
) (
  input  logic    clk,
  input  logic    rst,
  input  dpCmd_t  cmd,
  output dpStat_t stat,
  output logic    hiEn,
  output logic    cardEn
);

  // Counter widths sized from the largest legal ratio of each stage
  localparam int CNT1_W = (MAX_PRE_CODE < 1) ? 1 : MAX_PRE_CODE;
  localparam int CNT2_W = MAX_POST_CODE + 1;

  logic [PRE_W-1:0]  actPre;
  logic [POST_W-1:0] actPost;
  logic [CNT1_W-1:0] cnt1, lim1;
  logic [CNT2_W-1:0] cnt2, lim2;
  logic              hiTick, cardTick;

  assign lim1 = CNT1_W'((32'd1 << actPre) - 32'd1);
  assign lim2 = CNT2_W'((32'd2 << actPost) - 32'd1);

  assign hiTick   = cmd.runHi & (cnt1 == lim1);
  assign cardTick = hiTick & cmd.runCard & (cnt2 == lim2);

  // Active ratio codes, reloaded only on the control's load strobe
  always_ff @(posedge clk) begin
    if (rst) begin
      actPre  <= '0;
      actPost <= '0;
    end else if (cmd.load) begin
      actPre  <= cmd.newPre;
      actPost <= cmd.newPost;
    end
  end

  // First stage: source cycles within one intermediate period
  always_ff @(posedge clk) begin
    if (rst || !cmd.runHi || hiTick) cnt1 <= '0;
    else                             cnt1 <= cnt1 + 1'b1;
  end

  // Second stage: intermediate periods within one card period
  always_ff @(posedge clk) begin
    if (rst || !cmd.runCard) cnt2 <= '0;
    else if (hiTick)         cnt2 <= cardTick ? '0 : cnt2 + 1'b1;
  end

  assign hiEn   = hiTick & ~cmd.mute;
  assign cardEn = cardTick & ~cmd.mute;

  always_comb begin
    stat.hiTick   = hiTick;
    stat.cardTick = cardTick;
    stat.actPre   = actPre;
    stat.actPost  = actPost;
  end

endmodule

// File: rtl/sdclk_div.sv
module sdclk_div
  import sdclk_div_pkg::*;
#(
  parameter int DATA_W        = 32,
  parameter int MAX_PRE_CODE  = 4,
  parameter int MAX_POST_CODE = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              hiEn,
  output logic              cardEn,
  output logic              cfgErr
);

  dpCmd_t  cmd;
  dpStat_t stat;

  sdclk_div_ctrl #(
    .DATA_W(DATA_W), .MAX_PRE_CODE(MAX_PRE_CODE), .MAX_POST_CODE(MAX_POST_CODE)
  ) ctrl_i (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrData(wrData),
    .stat(stat), .cmd(cmd), .rdData(rdData), .cfgErr(cfgErr)
  );

  sdclk_div_datapath #(
    .MAX_PRE_CODE(MAX_PRE_CODE), .MAX_POST_CODE(MAX_POST_CODE)
  ) dp_i (
    .clk(clk), .rst(rst), .cmd(cmd), .stat(stat),
    .hiEn(hiEn), .cardEn(cardEn)
  );

endmodule

// File: rtl/sdclk_div_checker.sv
module sdclk_div_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] rdData,
  input logic              hiEn,
  input logic              cardEn,
  input logic              cfgErr
);

  localparam logic [DATA_W-1:0] KEPT = DATA_W'(32'h0000_031F);

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (rdData == DATA_W'(32'h0000_0300)) && !hiEn && !cardEn && !cfgErr);

  assert_unkept_bits_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (rdData & ~KEPT) == '0);

  assert_card_on_hi_R4: assert property (@(posedge clk) disable iff (rst)
    cardEn |-> hiEn);

  assert_stop_hi_mutes_R5: assert property (@(posedge clk) disable iff (rst)
    rdData[9] |-> (!hiEn && !cardEn));

  assert_stop_card_mutes_R5: assert property (@(posedge clk) disable iff (rst)
    rdData[8] |-> !cardEn);

  assert_err_mutes_R6: assert property (@(posedge clk) disable iff (rst)
    cfgErr |-> (!hiEn && !cardEn));

  assert_card_single_R9: assert property (@(posedge clk) disable iff (rst)
    cardEn |=> !cardEn);

endmodule

bind sdclk_div sdclk_div_checker #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .rdData(rdData),
  .hiEn(hiEn), .cardEn(cardEn), .cfgErr(cfgErr)
);

// File: tb/sdclk_div_tb_top.sv
module sdclk_div_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 100000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        hiEn, cardEn, cfgErr;

  int    checks = 0;
  int    fails = 0;
  string curReq = "R1";
  bit    started = 1'b0;
  bit    prevCard = 1'b0;
  bit    done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdclk_div dut_i (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .hiEn(hiEn), .cardEn(cardEn), .cfgErr(cfgErr)
  );

  // Behavioural reference model
  int mCtrl = 32'h300, mAct1 = 0, mAct2 = 0, mCnt1 = 0, mCnt2 = 0;

  function automatic bit legalW(int w);
    return (((w >> 2) & 7) <= 4) && ((w & 3) <= 1);
  endfunction

  function automatic bit runHiM();
    return ((mCtrl >> 9) & 1) == 0;
  endfunction

  function automatic bit runCardM();
    return runHiM() && (((mCtrl >> 8) & 1) == 0);
  endfunction

  function automatic bit hiTickM();
    return runHiM() && (mCnt1 == (1 << mAct1) - 1);
  endfunction

  function automatic bit cardTickM();
    return hiTickM() && runCardM() && (mCnt2 == ((mAct2 != 0) ? 4 : 2) - 1);
  endfunction

  always @(posedge clk) begin : modelUpdate
    int  nw;
    bit  ht, ct, r1, r2, bnd;
    started <= 1'b1;
    if (rst) begin
      mCtrl = 32'h300; mAct1 = 0; mAct2 = 0; mCnt1 = 0; mCnt2 = 0;
    end else begin
      ht = hiTickM(); ct = cardTickM(); r1 = runHiM(); r2 = runCardM();
      nw = wrEn ? int'(wrData & 32'h31F) : mCtrl;
      bnd = r2 ? ct : (r1 ? ht : 1'b1);
      if (legalW(nw) && ((((nw >> 2) & 7) != mAct1) || ((nw & 3) != mAct2)) && bnd) begin
        mAct1 = (nw >> 2) & 7;
        mAct2 = nw & 3;
      end
      if (!r1 || ht) mCnt1 = 0; else mCnt1 = mCnt1 + 1;
      if (!r2) mCnt2 = 0;
      else if (ht) mCnt2 = ct ? 0 : mCnt2 + 1;
      if (wrEn) mCtrl = int'(wrData & 32'h31F);
    end
  end

  // Compare every cycle away from the active edge
  always @(negedge clk) begin
    bit eErr, eHi, eCard;
    if (started && !done) begin
      eErr  = !legalW(mCtrl);
      eHi   = hiTickM() && !eErr;
      eCard = cardTickM() && !eErr;
      checks += 4;
      if (rdData !== 32'(mCtrl)) begin
        fails++; $display("FAIL R2 (%s) rdData actual=%h expected=%h", curReq, rdData, mCtrl);
      end
      if (hiEn !== eHi) begin
        fails++; $display("FAIL R3 (%s) hiEn actual=%b expected=%b t=%0t", curReq, hiEn, eHi, $time);
      end
      if (cardEn !== eCard) begin
        fails++; $display("FAIL R4 (%s) cardEn actual=%b expected=%b t=%0t", curReq, cardEn, eCard, $time);
      end
      if (cfgErr !== eErr) begin
        fails++; $display("FAIL R6 (%s) cfgErr actual=%b expected=%b", curReq, cfgErr, eErr);
      end
      if (cardEn) begin
        checks++;
        if (prevCard) begin
          fails++; $display("FAIL R9 cardEn actual=consecutive expected=isolated");
        end
      end
      prevCard = cardEn;
    end
  end

  task automatic writeReg(input logic [31:0] v);
    @(posedge clk); #1;
    wrEn = 1'b1; wrData = v;
    @(posedge clk); #1;
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // R8: measure cycles from the write cycle to the first pulse of each stage
  task automatic releaseLatency(input logic [31:0] v, input int d1, input int d2);
    int firstHi = -1, firstCard = -1;
    curReq = "R8";
    writeReg(v);
    for (int k = 1; k <= 80; k++) begin
      @(negedge clk);
      if (hiEn && firstHi < 0) firstHi = k;
      if (cardEn && firstCard < 0) firstCard = k;
    end
    checks += 2;
    if (firstHi != d1) begin
      fails++; $display("FAIL R8 first hiEn cycle actual=%0d expected=%0d", firstHi, d1);
    end
    if (firstCard != d1 * d2) begin
      fails++; $display("FAIL R8 first cardEn cycle actual=%0d expected=%0d", firstCard, d1 * d2);
    end
    #1;
  endtask

  initial begin : watchdog
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : stimulus
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    checks++;
    if (rdData !== 32'h300 || hiEn !== 1'b0 || cardEn !== 1'b0 || cfgErr !== 1'b0) begin
      fails++; $display("FAIL R1 reset state actual=%h/%b%b%b expected=00000300/000",
                        rdData, hiEn, cardEn, cfgErr);
    end
    rst = 1'b0;
    idle(4);

    // R8: release from stop with pre code 2, post code 1 (ratio 4 x 4)
    releaseLatency(32'h0000_0009, 4, 4);
    writeReg(32'h0000_0300);
    idle(3);
    releaseLatency(32'h0000_0000, 1, 2);

    // R3 / R4 / R7: sweep all legal ratios while running
    curReq = "R7";
    for (int p = 0; p <= 4; p++) begin
      for (int q = 0; q <= 1; q++) begin
        writeReg(32'((p << 2) | q));
        idle(40 + 8 * (1 << p));
      end
    end
    curReq = "R3";
    writeReg(32'h0000_0004);
    idle(60);
    curReq = "R4";
    writeReg(32'h0000_0005);
    idle(60);

    // R7: change in the middle of a long card period
    curReq = "R7";
    writeReg(32'h0000_0011);
    idle(37);
    writeReg(32'h0000_0000);
    idle(100);

    // R5: card stopped, only intermediate runs; ratio change at hi boundary (R7)
    curReq = "R5";
    writeReg(32'h0000_010C);
    idle(50);
    curReq = "R7";
    writeReg(32'h0000_0108);
    idle(50);
    curReq = "R5";
    writeReg(32'h0000_020D);
    idle(50);
    writeReg(32'h0000_030D);
    idle(30);
    // R7: stopped change applies at once; then release
    curReq = "R7";
    writeReg(32'h0000_0304);
    idle(5);
    releaseLatency(32'h0000_0004, 2, 2);

    // R6: illegal codes
    curReq = "R6";
    writeReg(32'h0000_0014);
    idle(40);
    writeReg(32'h0000_0002);
    idle(40);
    writeReg(32'h0000_001F);
    idle(40);
    writeReg(32'h0000_0009);
    idle(80);

    // R2: unkept bits read as zero
    curReq = "R2";
    writeReg(32'hFFFF_FFFF);
    idle(10);
    writeReg(32'hA5A5_A5A5);
    idle(10);
    writeReg(32'h5A5A_FC01);
    idle(20);
    checks++;
    if (rdData !== 32'h0000_0001) begin
      fails++; $display("FAIL R2 rdData actual=%h expected=00000001", rdData);
    end

    // R9: fastest card ratio
    curReq = "R9";
    writeReg(32'h0000_0000);
    idle(60);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule